// File: doc/BRIEF.md
# Segment Selector Privilege Checker

The block checks one segmented virtual address per request against a four-ring privilege model and turns it into a linear address. A request carries a 16-bit segment selector, a 32-bit offset, the current privilege level of the running code and a flag for instructions that only ring 0 may execute. The selector is split into a requested privilege level, a table bit that selects the global or the per-process (local) descriptor space, and a segment index.

A small register file holds, for each implemented slot of both spaces, a 32-bit base, a 32-bit limit, a 2-bit descriptor privilege level and a present bit. The file is loaded over a one-cycle write port. Each accepted request produces a registered response one cycle later. The response holds either a permit with the linear address (base plus offset) or a fault with a cause code. Requests and responses use a valid/ready handshake.

Top module: `seg_priv_check`

## Requirements
- R1: After reset rsp_valid is 0, req_ready is 1, and every slot of both spaces is absent.
- R2: Selector bits [1:0] are the requested level, bit 2 selects the space (0 global, 1 local), and bits [15:3] are the segment index. The same index in the two spaces addresses two separate slots.
- R3: A request whose index is at or above ENTRIES, or whose slot has never been written, faults with cause 2 (absent).
- R4: An offset greater than the slot's limit faults with cause 3 (limit). An offset equal to the limit is allowed.
- R5: The request faults with cause 4 (privilege) when the larger of the current and requested levels is numerically greater than the slot's descriptor level.
- R6: When the privileged-instruction flag is set and the current level is not 0, the request faults with cause 1.
- R7: When several faults apply, the lowest cause code is reported: 1 before 2 before 3 before 4. Cause 0 means permit.
- R8: On a permit rsp_lin is base plus offset modulo 2^32. On a fault rsp_lin is 0.
- R9: req_ready equals (not rsp_valid) or rsp_ready. A request accepted at one edge is presented in rsp_valid, rsp_cause and rsp_lin after that edge. A response is held unchanged while rsp_ready is low.
- R10: A write stores base, limit and descriptor level into slot {wr_local, wr_slot} and marks it present. A later write to the same slot replaces the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one descriptor slot |
| wr_local | input | 1 | Space of the slot being written (1 local) |
| wr_slot | input | IW | Slot index being written |
| wr_base | input | 32 | Segment base |
| wr_limit | input | 32 | Highest legal offset |
| wr_dpl | input | 2 | Descriptor privilege level |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_cpl | input | 2 | Current privilege level |
| req_priv_op | input | 1 | Access is a ring-0-only instruction |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_cause | output | 3 | 0 permit, 1 privileged op, 2 absent, 3 limit, 4 privilege |
| rsp_lin | output | 32 | Linear address, 0 on a fault |

## Verification
Each result appears one clock edge after the edge that accepts the request. The bench drives each request on a falling edge, lets it be accepted at the next rising edge, and samples rsp_cause and rsp_lin on the falling edge after that. A write becomes visible to requests accepted after the write's rising edge, so writes and the requests that depend on them are always separated by at least one full cycle. In the stall test, the response is sampled on two successive falling edges with rsp_ready low to confirm it is held. rsp_ready is then raised, and the next response is checked one edge later.

// File: rtl/seg_priv_check.sv
module seg_priv_check #(
  parameter int ENTRIES = 4,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_local,
  input  logic [IW-1:0] wr_slot,
  input  logic [31:0]   wr_base,
  input  logic [31:0]   wr_limit,
  input  logic [1:0]    wr_dpl,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [15:0]   req_sel,
  input  logic [31:0]   req_off,
  input  logic [1:0]    req_cpl,
  input  logic          req_priv_op,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [2:0]    rsp_cause,
  output logic [31:0]   rsp_lin
);
  localparam int SLOTS = 2 * ENTRIES;

  logic [31:0]      base_q  [SLOTS];
  logic [31:0]      limit_q [SLOTS];
  logic [1:0]       dpl_q   [SLOTS];
  logic [SLOTS-1:0] here_q;

  wire [IW:0] wr_ent = {wr_local, wr_slot};

  always_ff @(posedge clk)
    if (!rst_n) here_q <= '0;
    else if (wr_en) here_q[wr_ent] <= 1'b1;

  always_ff @(posedge clk)
    if (wr_en) begin
      base_q[wr_ent]  <= wr_base;
      limit_q[wr_ent] <= wr_limit;
      dpl_q[wr_ent]   <= wr_dpl;
    end

  wire [1:0]  rpl      = req_sel[1:0];
  wire [12:0] idx      = req_sel[15:3];
  wire        in_range = idx < 13'(ENTRIES);
  wire [IW:0] ent      = {req_sel[2], req_sel[IW+2:3]};
  wire [1:0]  eff      = (req_cpl > rpl) ? req_cpl : rpl;

  logic [2:0] cause;
  always_comb begin
    if (req_priv_op && req_cpl != 2'd0)    cause = 3'd1;
    else if (!(in_range && here_q[ent]))   cause = 3'd2;
    else if (req_off > limit_q[ent])       cause = 3'd3;
    else if (eff > dpl_q[ent])             cause = 3'd4;
    else                                   cause = 3'd0;
  end

  wire accept = req_valid && req_ready;
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk)
    if (!rst_n) rsp_valid <= 1'b0;
    else if (accept) rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;

  always_ff @(posedge clk)
    if (accept) begin
      rsp_cause <= cause;
      rsp_lin   <= (cause == 3'd0) ? base_q[ent] + req_off : 32'd0;
    end
endmodule

module seg_priv_check_sva #(
  parameter int ENTRIES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_sel,
  input logic [1:0]  req_cpl,
  input logic        req_priv_op,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [2:0]  rsp_cause,
  input logic [31:0] rsp_lin
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cause) && $stable(rsp_lin)));

  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  p_privop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_priv_op && req_cpl != 2'd0) |=> rsp_cause == 3'd1);

  p_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_priv_op && req_cpl != 2'd0)
     && req_sel[15:3] >= 13'(ENTRIES)) |=> rsp_cause == 3'd2);

  p_fault_lin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != 3'd0) |-> rsp_lin == 32'd0);

  p_cause_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_cause <= 3'd4);
endmodule

bind seg_priv_check seg_priv_check_sva #(.ENTRIES(ENTRIES)) i_sva (.*);

// File: tb/test_seg_priv_check.sv
`timescale 1ns/1ps
module test_seg_priv_check;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_local = 0;
  logic [IW-1:0] wr_slot = '0;
  logic [31:0] wr_base = 0, wr_limit = 0;
  logic [1:0] wr_dpl = 0;
  logic req_valid = 0, req_ready, req_priv_op = 0, rsp_valid, rsp_ready = 1;
  logic [15:0] req_sel = 0;
  logic [31:0] req_off = 0, rsp_lin;
  logic [1:0] req_cpl = 0;
  logic [2:0] rsp_cause;

  int checks = 0, errors = 0;
  logic [31:0] mb [2*N];
  logic [31:0] ml [2*N];
  logic [1:0]  md [2*N];
  bit          mp [2*N];

  always #4 clk = ~clk;

  seg_priv_check #(.ENTRIES(N)) i_seg_priv_check (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic [2:0] ecause(input [15:0] s, input [31:0] o, input [1:0] c, input bit p);
    int e;
    logic [1:0] eff;
    if (p && c != 0) return 3'd1;
    if (s[15:3] >= N) return 3'd2;
    e = s[2] * N + int'(s[15:3]);
    if (!mp[e]) return 3'd2;
    if (o > ml[e]) return 3'd3;
    eff = (c > s[1:0]) ? c : s[1:0];
    if (eff > md[e]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic [31:0] elin(input [15:0] s, input [31:0] o, input [1:0] c, input bit p);
    if (ecause(s, o, c, p) != 0) return 32'd0;
    return mb[s[2] * N + int'(s[15:3])] + o;
  endfunction

  task automatic wr(input bit loc, input int slot, input [31:0] b, input [31:0] l, input [1:0] d);
    @(negedge clk);
    wr_en = 1; wr_local = loc; wr_slot = IW'(slot); wr_base = b; wr_limit = l; wr_dpl = d;
    @(negedge clk);
    wr_en = 0;
    mb[loc*N+slot] = b; ml[loc*N+slot] = l; md[loc*N+slot] = d; mp[loc*N+slot] = 1;
  endtask

  function automatic [15:0] sel(input int idx, input bit loc, input [1:0] rpl);
    return {13'(idx), loc, rpl};
  endfunction

  task automatic rq(input string tag, input [15:0] s, input [31:0] o, input [1:0] c, input bit p);
    logic [2:0] ec;
    logic [31:0] el;
    ec = ecause(s, o, c, p); el = elin(s, o, c, p);
    @(negedge clk);
    req_sel = s; req_off = o; req_cpl = c; req_priv_op = p; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " cause"}, 32'(rsp_cause), 32'(ec));
    chk({tag, " lin"}, rsp_lin, el);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] hc;
    logic [31:0] hl;
    void'($urandom(32'd1234));
    for (int i = 0; i < 2*N; i++) begin mp[i] = 0; mb[i] = 0; ml[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    rq("R1 absent after reset", sel(0, 0, 0), 32'h10, 0, 0);

    wr(0, 0, 32'h0000_1000, 32'h0000_00FF, 3);
    wr(1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    wr(0, 1, 32'hFFFF_FF00, 32'h0000_0200, 1);
    rq("R2 global", sel(0, 0, 0), 32'h10, 0, 0);
    rq("R2 local", sel(0, 1, 0), 32'h10, 0, 0);
    rq("R4 at limit", sel(0, 0, 3), 32'hFF, 3, 0);
    rq("R4 over limit", sel(0, 0, 0), 32'h100, 0, 0);
    rq("R5 ok", sel(1, 0, 0), 32'h20, 1, 0);
    rq("R5 rpl", sel(1, 0, 2), 32'h20, 0, 0);
    rq("R5 cpl", sel(1, 0, 0), 32'h20, 2, 0);
    rq("R6 ring0 ok", sel(0, 0, 0), 32'h4, 0, 1);
    rq("R6 ring3", sel(0, 0, 0), 32'h4, 3, 1);
    rq("R7 privop over absent", sel(N, 0, 0), 32'h4, 1, 1);
    rq("R7 limit over privilege", sel(1, 0, 3), 32'h300, 3, 0);
    rq("R3 index out of range", sel(N, 1, 0), 32'h0, 0, 0);
    rq("R3 unloaded slot", sel(3, 0, 0), 32'h0, 0, 0);
    rq("R8 wrap", sel(1, 0, 1), 32'h1FF, 1, 0);
    wr(0, 0, 32'h0002_0000, 32'h0000_FFFF, 2);
    rq("R10 overwrite", sel(0, 0, 2), 32'hFFFF, 2, 0);

    @(negedge clk);
    rsp_ready = 0;
    req_sel = sel(0, 1, 0); req_off = 32'h44; req_cpl = 0; req_priv_op = 0; req_valid = 1;
    @(negedge clk);
    chk("R9 accepted", 32'(rsp_valid), 1);
    chk("R9 stall not ready", 32'(req_ready), 0);
    hc = rsp_cause; hl = rsp_lin;
    chk("R9 first lin", hl, 32'h8000_0044);
    req_sel = sel(0, 0, 0); req_off = 32'h8;
    @(negedge clk);
    chk("R9 hold cause", 32'(rsp_cause), 32'(hc));
    chk("R9 hold lin", rsp_lin, hl);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R9 second lin", rsp_lin, 32'h0002_0008);
    @(negedge clk);
    chk("R9 drain", 32'(rsp_valid), 0);

    for (int i = 0; i < 400; i++) begin
      int idx;
      bit loc;
      logic [31:0] off;
      if ($urandom_range(0, 7) == 0)
        wr($urandom_range(0, 1), $urandom_range(0, N-1), $urandom,
           32'($urandom_range(0, 4095)), 2'($urandom_range(0, 3)));
      idx = $urandom_range(0, N);
      loc = $urandom_range(0, 1);
      off = 32'($urandom_range(0, 5000));
      rq("R7 random", sel(idx, loc, 2'($urandom_range(0, 3))), off,
         2'($urandom_range(0, 3)), $urandom_range(0, 5) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule